// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block sits between a set of peripheral interrupt lines and a processor that fetches interrupt vector numbers over its data bus. Each source line is watched for a rising edge, which marks that source as pending. While any source is pending, the controller raises a single interrupt request towards the processor. When the processor answers with an interrupt acknowledge cycle, the controller picks the lowest-numbered pending source. It places that source's 8-bit vector number on the low byte of the data bus and signals data-transfer acknowledge. The processor then multiplies the number by four to locate the service routine address in its table.

Every source owns a programmable vector register. The processor reserves table slots 0 to 63 for its own exceptions, and slots 0 and 1 hold the reset stack pointer and reset program counter. The controller therefore accepts only vector values from 64 to 255 and silently refuses anything lower. If an acknowledge cycle arrives while nothing is pending, the controller answers with a bus error and drives no vector.

The control state machine has three states. ST_IDLE waits for an acknowledge cycle. ST_ACK_VEC drives the vector with acknowledge asserted. ST_ACK_ERR holds bus error. The transitions are:
- "grant": ST_IDLE to ST_ACK_VEC, taken when an acknowledge cycle is seen and a source is pending.
- "empty": ST_IDLE to ST_ACK_ERR, taken when an acknowledge cycle is seen and nothing is pending.
- "release": ST_ACK_VEC or ST_ACK_ERR back to ST_IDLE, taken when the address strobe goes high.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset `int_req` is 0, `dtack_n` and `berr_n` are 1, `data_oe` is 0, and the vector register of source i holds 64+i.
- R2: A 0-to-1 transition on `src_req[i]` sets the pending flag of source i one clock edge later; a level that stays high does not set the flag again after it has been cleared.
- R3: `int_req` is 1 exactly while at least one source is pending.
- R4: An acknowledge cycle is recognised only when `fc` equals 3'b111 and `as_n` is 0 at a clock edge; any other `fc` value with `as_n` low produces neither acknowledge nor bus error.
- R5: With several sources pending, the lowest-numbered source is delivered first.
- R6: One edge after the acknowledge cycle is recognised with a source pending, `dtack_n` is 0, `data_oe` is 1 and `data_lo` carries that source's vector; these stay unchanged until the strobe is released.
- R7: The delivered source's pending flag is cleared at the edge where it is granted; other pending flags are kept.
- R8: An acknowledge cycle with nothing pending yields `berr_n` 0 one edge later, with `dtack_n` 1 and `data_oe` 0; acknowledge and bus error are never both low.
- R9: A write with `cfg_we` 1 stores `cfg_vec` into the register selected by `cfg_sel` when the value is 64 or more; a value below 64 is rejected and the register keeps its previous value.
- R10: One edge after `as_n` is sampled high, `dtack_n`, `berr_n` and `data_oe` are back at their idle values.
- R11: A driven vector is never below 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Peripheral interrupt lines, rising edge marks pending |
| int_req | output | 1 | Interrupt request to the processor |
| fc | input | 3 | Processor function code |
| as_n | input | 1 | Address strobe, active low |
| data_lo | output | VEC_W | Vector number for the data bus low byte |
| data_oe | output | 1 | Drive enable for `data_lo` |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |
| cfg_we | input | 1 | Vector register write strobe |
| cfg_sel | input | $clog2(NSRC) | Source whose vector register is written |
| cfg_vec | input | VEC_W | Vector value to write |

## Verification
The hardest case to reach is a source line that stays high across its own delivery. This case separates edge capture from level sensing, because a level-sensing design would raise the request again at once. The stimulus holds one line high, completes an acknowledge cycle that delivers it, and then checks that `int_req` stays low with the line still high. A second hard case is priority draining with every source pending at once. All lines are pulsed in one cycle, and back-to-back acknowledge cycles must return the vectors in ascending source order. The scoreboard holds the expected order in its queue.

// File: rtl/vic_pkg.sv
package vic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK_VEC = 2'd1,
        ST_ACK_ERR = 2'd2
    } vic_state_t;

    localparam logic [2:0] FC_IACK = 3'b111;
    localparam int         VEC_MIN = 64;
endpackage

// File: rtl/vic_pending.sv
module vic_pending #(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NSRC-1:0]  pending
);
    logic [NSRC-1:0] src_prev;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr_mask;

    assign rise = src_req & ~src_prev;

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        assign clr_mask[i] = clr_en && (clr_idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev <= '0;
            pending  <= '0;
        end else begin
            src_prev <= src_req;
            pending  <= (pending & ~clr_mask) | rise;
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3
) (
    input  logic [NSRC-1:0]  pending,
    output logic             any,
    output logic [IDX_W-1:0] win_idx
);
    always_comb begin
        win_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pending[i]) win_idx = IDX_W'(i);
        end
    end

    assign any = |pending;
endmodule

// File: rtl/vic_vecregs.sv
module vic_vecregs
    import vic_pkg::*;
#(
    parameter int NSRC  = 8,
    parameter int IDX_W = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic [VEC_W-1:0] cfg_vec,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_vec
);
    logic [VEC_W-1:0] vec_q [NSRC];
    logic             val_ok;

    assign val_ok = (int'(cfg_vec) >= VEC_MIN);

    for (genvar i = 0; i < NSRC; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_q[i] <= VEC_W'(VEC_MIN + i);
            end else if (cfg_we && val_ok && (cfg_sel == IDX_W'(i))) begin
                vec_q[i] <= cfg_vec;
            end
        end
    end

    assign rd_vec = vec_q[rd_idx];
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int  NSRC  = 8,
    parameter int  VEC_W = 8,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req,
    output logic             int_req,
    input  logic [2:0]       fc,
    input  logic             as_n,
    output logic [VEC_W-1:0] data_lo,
    output logic             data_oe,
    output logic             dtack_n,
    output logic             berr_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_sel,
    input  logic [VEC_W-1:0] cfg_vec
);
    vic_state_t       state_q, state_d;
    logic [NSRC-1:0]  pending;
    logic             any;
    logic [IDX_W-1:0] win_idx;
    logic [VEC_W-1:0] win_vec;
    logic [VEC_W-1:0] vec_q;
    logic             ack_seen;
    logic             clr_en;

    assign ack_seen = (fc == FC_IACK) && !as_n;
    assign clr_en   = (state_q == ST_IDLE) && ack_seen && any;
    assign int_req  = any;

    vic_pending #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_req (src_req),
        .clr_en  (clr_en),
        .clr_idx (win_idx),
        .pending (pending)
    );

    vic_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
        .pending (pending),
        .any     (any),
        .win_idx (win_idx)
    );

    vic_vecregs #(.NSRC(NSRC), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_vregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .cfg_vec (cfg_vec),
        .rd_idx  (win_idx),
        .rd_vec  (win_vec)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ack_seen) state_d = any ? ST_ACK_VEC : ST_ACK_ERR;
            end
            ST_ACK_VEC, ST_ACK_ERR: begin
                if (as_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= VEC_W'(VEC_MIN);
        end else begin
            state_q <= state_d;
            if (clr_en) vec_q <= win_vec;
        end
    end

    always_comb begin
        data_lo = '0;
        data_oe = 1'b0;
        dtack_n = 1'b1;
        berr_n  = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK_VEC: begin
                data_lo = vec_q;
                data_oe = 1'b1;
                dtack_n = 1'b0;
            end
            ST_ACK_ERR: berr_n = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       fc,
    input logic             as_n,
    input logic [VEC_W-1:0] data_lo,
    input logic             data_oe,
    input logic             dtack_n,
    input logic             berr_n
);
    a_r11_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (int'(data_lo) >= 64));

    a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dtack_n && !berr_n));

    a_r4_ack_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(fc == 3'b111 && !as_n));

    a_r4_err_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(berr_n) |-> $past(fc == 3'b111 && !as_n));

    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        $past(as_n) |-> (dtack_n && berr_n && !data_oe));

    a_r6_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && $past(!dtack_n)) |-> $stable(data_lo));
endmodule

bind vec_irq_ctrl vic_checker #(.VEC_W(VEC_W)) u_vic_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fc      (fc),
    .as_n    (as_n),
    .data_lo (data_lo),
    .data_oe (data_oe),
    .dtack_n (dtack_n),
    .berr_n  (berr_n)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
    localparam int NSRC  = 8;
    localparam int VEC_W = 8;
    localparam int IDX_W = $clog2(NSRC);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_req = '0;
    logic             int_req;
    logic [2:0]       fc = 3'b000;
    logic             as_n = 1'b1;
    logic [VEC_W-1:0] data_lo;
    logic             data_oe;
    logic             dtack_n;
    logic             berr_n;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_sel = '0;
    logic [VEC_W-1:0] cfg_vec = '0;

    always #10 clk = ~clk;

    vec_irq_ctrl #(.NSRC(NSRC), .VEC_W(VEC_W)) uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .int_req(int_req),
        .fc(fc), .as_n(as_n), .data_lo(data_lo), .data_oe(data_oe),
        .dtack_n(dtack_n), .berr_n(berr_n), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_vec(cfg_vec)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // expected item: bit 8 = error response, bits 7:0 = vector
    logic [8:0] exp_q [$];
    int         model_vec [NSRC];
    bit         model_pend [NSRC];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // monitor: pops an expected item at each new response
    initial begin
        bit prev_active = 0;
        forever begin
            @(negedge clk);
            if (rst_n && (!dtack_n || !berr_n) && !prev_active) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected response", 1, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    if (e[8]) begin
                        check(!berr_n && dtack_n && !data_oe, "R8",
                              "bus error response", {dtack_n, berr_n, data_oe}, 3'b100);
                    end else begin
                        check(!dtack_n && data_oe, "R6", "vector acknowledge",
                              {dtack_n, data_oe}, 2'b01);
                        check(data_lo == e[7:0], "R5", "delivered vector",
                              data_lo, e[7:0]);
                    end
                end
            end
            prev_active = (!dtack_n || !berr_n);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "R10", "watchdog expired", 0, 1);
        report();
    end

    task automatic pulse(input logic [NSRC-1:0] m);
        @(negedge clk);
        src_req = src_req | m;
        for (int i = 0; i < NSRC; i++) if (m[i]) model_pend[i] = 1;
        @(negedge clk);
        src_req = src_req & ~m;
    endtask

    task automatic cfg_write(input int sel, input int val);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_sel = IDX_W'(sel);
        cfg_vec = VEC_W'(val);
        if (val >= 64) model_vec[sel] = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: predicts the response, pushes it, runs the cycle
    task automatic ack_cycle();
        int win = -1;
        for (int i = NSRC - 1; i >= 0; i--) if (model_pend[i]) win = i;
        if (win < 0) begin
            exp_q.push_back({1'b1, 8'd0});
        end else begin
            exp_q.push_back({1'b0, 8'(model_vec[win])});
            model_pend[win] = 0;
        end
        @(negedge clk);
        fc   = 3'b111;
        as_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (win >= 0)
            check(!dtack_n && data_lo == 8'(model_vec[win]), "R6",
                  "held while strobe low", data_lo, model_vec[win]);
        as_n = 1'b1;
        fc   = 3'b000;
        @(negedge clk);
        check(dtack_n && berr_n && !data_oe, "R10", "idle after release",
              {dtack_n, berr_n, data_oe}, 3'b110);
    endtask

    function automatic bit any_model();
        bit a = 0;
        for (int i = 0; i < NSRC; i++) a |= model_pend[i];
        return a;
    endfunction

    initial begin
        for (int i = 0; i < NSRC; i++) begin
            model_vec[i]  = 64 + i;
            model_pend[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!int_req && dtack_n && berr_n && !data_oe, "R1", "reset outputs",
              {int_req, dtack_n, berr_n, data_oe}, 4'b0110);

        // R8 acknowledge with nothing pending
        ack_cycle();

        // R4 wrong function code ignored
        pulse(8'h04);
        check(int_req, "R2", "edge sets pending", int_req, 1);
        @(negedge clk);
        fc = 3'b101; as_n = 1'b0;
        repeat (3) @(negedge clk);
        check(dtack_n && berr_n, "R4", "no response on other fc",
              {dtack_n, berr_n}, 2'b11);
        as_n = 1'b1; fc = 3'b000;
        @(negedge clk);

        // R5 priority, R7 others kept
        pulse(8'h20);
        ack_cycle();
        check(int_req, "R7", "other source still pending", int_req, 1);
        ack_cycle();
        check(!int_req, "R3", "request drops when empty", int_req, 0);

        // R2 held level does not re-arm
        @(negedge clk);
        src_req[3] = 1'b1;
        model_pend[3] = 1;
        @(negedge clk);
        ack_cycle();
        repeat (2) @(negedge clk);
        check(!int_req, "R2", "held line not re-pending", int_req, 0);
        src_req[3] = 1'b0;

        // R9 programming
        cfg_write(0, 8'h30);
        cfg_write(1, 64);
        cfg_write(7, 255);
        cfg_write(2, 200);
        cfg_write(2, 63);
        pulse(8'h01);
        ack_cycle();   // rejected write leaves 64
        pulse(8'h02);
        ack_cycle();   // 64 accepted
        pulse(8'h84);
        ack_cycle();   // source 2 -> 200
        ack_cycle();   // source 7 -> 255

        // R5 all sources at once drain in order
        pulse('1);
        check(int_req, "R3", "request with all pending", int_req, 1);
        for (int k = 0; k < NSRC; k++) ack_cycle();
        check(!int_req == !any_model(), "R3", "empty after drain", int_req, 0);
        ack_cycle();   // R8 again

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6", "all responses seen", exp_q.size(), 0);
        report();
    end
endmodule